// File: doc/BRIEF.md
# Eight-Point IDCT Row Pass

This block runs the first, horizontal pass of a separable 8×8 inverse DCT on a single row. It takes eight signed 16-bit frequency coefficients, forms four even-index sums and four odd-index sums from fixed 14-bit-scaled cosine weights, combines them in a butterfly, then rounds and shifts them arithmetically right by 11. The result is eight signed 16-bit intermediate samples, ready to be written as one column of a transpose store.

Rows arrive on a valid/ready handshake. The block takes one row per cycle. Eight results appear together one cycle after a row is taken, and they are held until the consumer takes them. If every coefficient except the first is zero, the block skips the weighted sums and fills all eight outputs with the first coefficient scaled by eight. If the upper four coefficients are zero, the block gates off their products, and the results are unchanged.

Top module: `idct8_row_pass`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: A row is taken in a cycle where in_valid and in_ready are both 1. In the next cycle out_valid is 1 and out_res holds that row's results.
- R3: While out_valid is 1 and out_ready is 0, out_res keeps its value, out_valid stays 1 and in_ready is 0.
- R4: Even sums use weights c1=22725, c2=21407, c3=19266, c4=16383, c5=12873, c6=8867, c7=4520. A0=c4·x0+c2·x2+c4·x4+c6·x6, A1=c4·x0+c6·x2−c4·x4−c2·x6, A2=c4·x0−c6·x2−c4·x4+c2·x6, A3=c4·x0−c2·x2+c4·x4−c6·x6. Each sum has 1024 added. Coefficient xi sits at in_coef bits [16i+15:16i].
- R5: Odd sums are B0=c1·x1+c3·x3+c5·x5+c7·x7, B1=c3·x1−c7·x3−c1·x5−c5·x7, B2=c5·x1−c1·x3+c7·x5+c3·x7 and B3=c7·x1−c5·x3+c3·x5−c1·x7.
- R6: For k=0..3, lane k is (Ak+Bk)>>>11 and lane 7−k is (Ak−Bk)>>>11, each cut to its low 16 bits. Lane n sits at out_res bits [16n+15:16n].
- R7: When x1..x7 are all zero, every lane equals x0 shifted left by 3, cut to 16 bits. This is not the rounded weighted value.
- R8: When x4..x7 are all zero (and the row is not DC-only), the results are identical to R4–R6.
- R9: With out_ready held at 1, a new row can be taken in every cycle. A held result that is consumed with no new row taken leaves out_valid at 0.
- R10: Sums are carried without overflow, so rows of full-scale coefficients (±32767, −32768) give the R6 values exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A coefficient row is offered |
| in_ready | output | 1 | The block can take a row this cycle |
| in_coef | input | 128 | Eight signed coefficients, xi in bits [16i+15:16i] |
| out_valid | output | 1 | out_res holds a result row |
| out_ready | input | 1 | The consumer takes the result row |
| out_res | output | 128 | Eight signed results, lane n in bits [16n+15:16n] |

## Verification
Two functions can fall in the same cycle: handing off a held result and taking a new row. That happens whenever out_ready and in_valid are both high while out_valid is set. The bench provokes it with random valid/ready densities, including a phase where both are always high. A behavioural model computes each lane directly from a cosine index table. Every cycle it judges whether the register was replaced by the new row, cleared, or kept. DC-only and half-zero rows are mixed into the same streams, so the fast path also has to line up with the handshake.

// File: rtl/idct8_row_pkg.sv
package idct8_row_pkg;
    // cos(k*pi/16)*sqrt(2)*2^14, rounded; index 4 deliberately one below 2^14
    localparam int C1 = 22725;
    localparam int C2 = 21407;
    localparam int C3 = 19266;
    localparam int C4 = 16383;
    localparam int C5 = 12873;
    localparam int C6 = 8867;
    localparam int C7 = 4520;
    localparam int LANES = 8;
    localparam int HALF  = LANES / 2;
endpackage

// File: rtl/idct8_even.sv
module idct8_even
    import idct8_row_pkg::*;
#(
    parameter int COEF_W = 16,
    parameter int ACC_W  = 34,
    parameter int SHIFT  = 11
) (
    input  logic signed [COEF_W-1:0]  x0,
    input  logic signed [COEF_W-1:0]  x2,
    input  logic signed [COEF_W-1:0]  x4,
    input  logic signed [COEF_W-1:0]  x6,
    input  logic                      gate_hi,
    input  logic                      gate_all,
    output logic [HALF*ACC_W-1:0]     a_all
);
    localparam logic signed [ACC_W-1:0] K2  = ACC_W'(C2);
    localparam logic signed [ACC_W-1:0] K4  = ACC_W'(C4);
    localparam logic signed [ACC_W-1:0] K6  = ACC_W'(C6);
    localparam logic signed [ACC_W-1:0] RND = ACC_W'(1) <<< (SHIFT - 1);

    logic signed [ACC_W-1:0] e0, e2, e4, e6;
    logic signed [ACC_W-1:0] p0, p2a, p2b, p4, p6a, p6b;

    always_comb begin
        // operand isolation: zeroed operands keep the multipliers quiet
        e0 = gate_all              ? '0 : ACC_W'(x0);
        e2 = gate_all              ? '0 : ACC_W'(x2);
        e4 = (gate_all || gate_hi) ? '0 : ACC_W'(x4);
        e6 = (gate_all || gate_hi) ? '0 : ACC_W'(x6);
        p0  = K4 * e0;
        p2a = K2 * e2;
        p2b = K6 * e2;
        p4  = K4 * e4;
        p6a = K6 * e6;
        p6b = K2 * e6;
        a_all[0*ACC_W +: ACC_W] = RND + p0 + p2a + p4 + p6a;
        a_all[1*ACC_W +: ACC_W] = RND + p0 + p2b - p4 - p6b;
        a_all[2*ACC_W +: ACC_W] = RND + p0 - p2b - p4 + p6b;
        a_all[3*ACC_W +: ACC_W] = RND + p0 - p2a + p4 - p6a;
    end
endmodule

// File: rtl/idct8_odd.sv
module idct8_odd
    import idct8_row_pkg::*;
#(
    parameter int COEF_W = 16,
    parameter int ACC_W  = 34
) (
    input  logic signed [COEF_W-1:0]  x1,
    input  logic signed [COEF_W-1:0]  x3,
    input  logic signed [COEF_W-1:0]  x5,
    input  logic signed [COEF_W-1:0]  x7,
    input  logic                      gate_hi,
    input  logic                      gate_all,
    output logic [HALF*ACC_W-1:0]     b_all
);
    localparam logic signed [ACC_W-1:0] K1 = ACC_W'(C1);
    localparam logic signed [ACC_W-1:0] K3 = ACC_W'(C3);
    localparam logic signed [ACC_W-1:0] K5 = ACC_W'(C5);
    localparam logic signed [ACC_W-1:0] K7 = ACC_W'(C7);

    logic signed [ACC_W-1:0] o1, o3, o5, o7;

    always_comb begin
        o1 = gate_all              ? '0 : ACC_W'(x1);
        o3 = gate_all              ? '0 : ACC_W'(x3);
        o5 = (gate_all || gate_hi) ? '0 : ACC_W'(x5);
        o7 = (gate_all || gate_hi) ? '0 : ACC_W'(x7);
        b_all[0*ACC_W +: ACC_W] = K1*o1 + K3*o3 + K5*o5 + K7*o7;
        b_all[1*ACC_W +: ACC_W] = K3*o1 - K7*o3 - K1*o5 - K5*o7;
        b_all[2*ACC_W +: ACC_W] = K5*o1 - K1*o3 + K7*o5 + K3*o7;
        b_all[3*ACC_W +: ACC_W] = K7*o1 - K5*o3 + K3*o5 - K1*o7;
    end
endmodule

// File: rtl/idct8_butterfly.sv
module idct8_butterfly
    import idct8_row_pkg::*;
#(
    parameter int COEF_W = 16,
    parameter int ACC_W  = 34,
    parameter int SHIFT  = 11
) (
    input  logic [HALF*ACC_W-1:0]   a_all,
    input  logic [HALF*ACC_W-1:0]   b_all,
    output logic [LANES*COEF_W-1:0] y
);
    localparam int SUM_W = ACC_W + 1;

    for (genvar k = 0; k < HALF; k++) begin : g_pair
        logic signed [SUM_W-1:0] ak, bk, sum_k, dif_k;
        assign ak    = SUM_W'($signed(a_all[k*ACC_W +: ACC_W]));
        assign bk    = SUM_W'($signed(b_all[k*ACC_W +: ACC_W]));
        assign sum_k = ak + bk;
        assign dif_k = ak - bk;
        assign y[k*COEF_W +: COEF_W]           = COEF_W'(sum_k >>> SHIFT);
        assign y[(LANES-1-k)*COEF_W +: COEF_W] = COEF_W'(dif_k >>> SHIFT);
    end
endmodule

// File: rtl/idct8_row_pass.sv
module idct8_row_pass
    import idct8_row_pkg::*;
#(
    parameter int COEF_W   = 16,
    parameter int ACC_W    = 34,
    parameter int SHIFT    = 11,
    parameter int DC_SHIFT = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [LANES*COEF_W-1:0]  in_coef,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [LANES*COEF_W-1:0]  out_res
);
    localparam int VEC_W = LANES * COEF_W;

    typedef struct packed {
        logic             vld;
        logic [VEC_W-1:0] res;
    } state_t;

    state_t s_d, s_q;

    logic signed [COEF_W-1:0] x [LANES];
    logic                     dc_only, hi_zero;
    logic [HALF*ACC_W-1:0]    a_all, b_all;
    logic [VEC_W-1:0]         bfly_res, dc_res;

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            x[i] = $signed(in_coef[i*COEF_W +: COEF_W]);
        end
        dc_only = (in_coef[VEC_W-1:COEF_W] == '0);
        hi_zero = (in_coef[VEC_W-1:HALF*COEF_W] == '0);
        for (int i = 0; i < LANES; i++) begin
            dc_res[i*COEF_W +: COEF_W] = in_coef[COEF_W-1:0] << DC_SHIFT;
        end
    end

    idct8_even #(.COEF_W(COEF_W), .ACC_W(ACC_W), .SHIFT(SHIFT)) u_even (
        .x0(x[0]), .x2(x[2]), .x4(x[4]), .x6(x[6]),
        .gate_hi(hi_zero), .gate_all(dc_only), .a_all(a_all)
    );

    idct8_odd #(.COEF_W(COEF_W), .ACC_W(ACC_W)) u_odd (
        .x1(x[1]), .x3(x[3]), .x5(x[5]), .x7(x[7]),
        .gate_hi(hi_zero), .gate_all(dc_only), .b_all(b_all)
    );

    idct8_butterfly #(.COEF_W(COEF_W), .ACC_W(ACC_W), .SHIFT(SHIFT)) u_bfly (
        .a_all(a_all), .b_all(b_all), .y(bfly_res)
    );

    always_comb begin
        s_d      = s_q;
        in_ready = !s_q.vld || out_ready;
        if (in_valid && in_ready) begin
            s_d.vld = 1'b1;
            s_d.res = dc_only ? dc_res : bfly_res;
        end else if (out_ready) begin
            s_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_valid = s_q.vld;
    assign out_res   = s_q.res;
endmodule

// File: rtl/idct8_row_chk.sv
module idct8_row_chk
    import idct8_row_pkg::*;
#(
    parameter int COEF_W   = 16,
    parameter int DC_SHIFT = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    in_ready,
    input logic [LANES*COEF_W-1:0] in_coef,
    input logic                    out_valid,
    input logic                    out_ready,
    input logic [LANES*COEF_W-1:0] out_res
);
    localparam int VEC_W = LANES * COEF_W;

    logic [COEF_W-1:0] dc_lane;
    logic              dc_row;
    assign dc_lane = in_coef[COEF_W-1:0] << DC_SHIFT;
    assign dc_row  = (in_coef[VEC_W-1:COEF_W] == '0);

    AST_TAKE_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid); // R2

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_res))); // R3

    AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready); // R3

    AST_DC_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && dc_row) |=> (out_res == {LANES{$past(dc_lane)}})); // R7

    AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !in_valid) |=> !out_valid); // R9
endmodule

bind idct8_row_pass idct8_row_chk #(.COEF_W(COEF_W), .DC_SHIFT(DC_SHIFT)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_coef(in_coef), .out_valid(out_valid), .out_ready(out_ready), .out_res(out_res)
);

// File: tb/idct8_row_pass_bench.sv
module idct8_row_pass_bench;
    localparam int CW = 16;
    localparam int NL = 8;
    localparam int VW = CW * NL;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          out_ready = 1'b0;
    logic [VW-1:0] in_coef = '0;
    logic          in_ready, out_valid;
    logic [VW-1:0] out_res;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    logic          m_vld;
    logic [VW-1:0] m_res;

    always #10 clk = ~clk;

    idct8_row_pass u_idct8_row_pass (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_coef(in_coef), .out_valid(out_valid), .out_ready(out_ready),
        .out_res(out_res)
    );

    function automatic longint wtab(input int m);
        case (m)
            0: return 16383; 1: return 22725; 2: return 21407; 3: return 19266;
            4: return 16383; 5: return 12873; 6: return 8867;  7: return 4520;
            default: return 0;
        endcase
    endfunction

    // behavioural model: lane n = sum_k x_k * cos((2n+1)k*pi/16) weight
    function automatic logic [VW-1:0] ref_row(input logic [VW-1:0] c);
        logic [VW-1:0] r;
        if (c[VW-1:CW] == '0) begin
            for (int n = 0; n < NL; n++) r[n*CW +: CW] = c[CW-1:0] << 3;
            return r;
        end
        for (int n = 0; n < NL; n++) begin
            longint acc = 1024;
            for (int k = 0; k < NL; k++) begin
                int     m = ((2*n + 1) * k) % 32;
                longint wv;
                bit     neg = 1'b0;
                if (m > 16) m = 32 - m;
                if (m > 8) begin m = 16 - m; neg = 1'b1; end
                wv = wtab(m);
                if (neg) wv = -wv;
                acc += wv * longint'($signed(c[k*CW +: CW]));
            end
            acc = acc >>> 11;
            r[n*CW +: CW] = acc[CW-1:0];
        end
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) m_vld <= 1'b0;
        else if (in_valid && (!m_vld || out_ready)) begin
            m_vld <= 1'b1;
            m_res <= ref_row(in_coef);
        end else if (out_ready) m_vld <= 1'b0;
    end

    task automatic check(input string req, input string what,
                         input logic [VW-1:0] act, input logic [VW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [VW-1:0] gen(input int mode);
        logic [VW-1:0] c;
        for (int k = 0; k < NL; k++) c[k*CW +: CW] = CW'($urandom);
        case (mode)
            1: for (int k = 1; k < NL; k += 2) c[k*CW +: CW] = '0; // even only
            2: c[0 +: CW] = '0;                                      // odd heavy
            3: begin                                                  // DC only
                c[VW-1:CW] = '0;
                case ($urandom % 4)
                    0: c[0 +: CW] = 16'd4095;
                    1: c[0 +: CW] = 16'd5000;
                    2: c[0 +: CW] = 16'hFFFF;
                    default: ;
                endcase
            end
            4: c[VW-1:4*CW] = '0;                                     // upper half zero
            5: for (int k = 0; k < NL; k++)
                   c[k*CW +: CW] = ($urandom % 2) ? 16'h7FFF : 16'h8000;
            default: ;
        endcase
        if (mode == 2) for (int k = 2; k < NL; k += 2) c[k*CW +: CW] = '0;
        return c;
    endfunction

    task automatic phase(input string req, input int cycles, input int mode,
                         input int vpct, input int rpct);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            check(req, "out_valid", VW'(out_valid), VW'(m_vld));
            check(req, "in_ready", VW'(in_ready), VW'(!m_vld || out_ready));
            if (m_vld) check(req, "out_res", out_res, m_res);
            in_valid  = (($urandom % 100) < vpct);
            out_ready = (($urandom % 100) < rpct);
            in_coef   = gen(mode);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "out_valid", VW'(out_valid), '0);
        check("R1", "in_ready", VW'(in_ready), VW'(1));
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "out_valid", VW'(out_valid), '0);
        phase("R2", 300, 0, 70, 70);
        phase("R4", 300, 1, 80, 80);
        phase("R5", 300, 2, 80, 80);
        phase("R6", 300, 0, 90, 100);
        phase("R7", 300, 3, 80, 60);
        phase("R8", 300, 4, 80, 80);
        phase("R9", 300, 0, 100, 100);
        phase("R3", 300, 0, 90, 20);
        phase("R10", 300, 5, 80, 80);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R2 watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule